// File: doc/BRIEF.md
# CPU-to-PCI Address Window Decoder

This block sits on the CPU side of a host bridge. It decides whether a CPU physical address falls inside a programmable PCI I/O window or inside a fixed 4 KB internal register window. Software sets up the I/O window through two 2 MB-granular decode registers: a low register that gives the first block and a high register that gives the last block. A write to the low register also loads a shadow remap register. A fourth register places the internal register window.

When the decode registers change, the block works out the window's base and length. It rejects a configuration in which the first block lies past the last block. It then trims the window so that it never covers either of two fixed reserved address holes. For each CPU address presented, it reports a registered hit flag and the offset of the address inside the window. Every register can be read back through a select-driven read port.

Top module: `pciwin_decoder`

## Requirements
- R1: A write with `wr_sel` = 0 (low decode) stores `wr_data[14:0]`. Reading back with `rd_sel` = 0 returns that value with all upper bits zero.
- R2: A write to the low decode register also loads the remap register with `wr_data[10:0]` in the same clock.
- R3: A write with `wr_sel` = 1 (high decode) stores only `wr_data[6:0]`. A write with `wr_sel` = 2 (remap) stores `wr_data[10:0]`. A write with `wr_sel` = 3 (internal window) stores `wr_data[14:0]`.
- R4: After reset the registers hold low = 0x080, high = 0x00F, remap = 0x080 and internal window = 0x0A0. The I/O window then covers 0x10000000 up to but not including 0x12000000, and the internal window starts at 0x14000000.
- R5: The decode is valid when low[6:0] <= high. When it is valid, the window base is low << 21 and the window length is ((high + 1) - low[6:0]) << 21. When it is not valid, the previous window stays in force, although the register still takes the written value.
- R6: The first reserved hole spans 0x1E000000 to 0x1F0FFFFF. A window end inside this hole is moved down to 0x1E000000. A window base inside this hole is moved up to 0x1F100000.
- R7: The second reserved hole spans 0x1FC00000 to 0x1FCFFFFF. A window end inside this hole is moved down to 0x1FC00000. A window base inside this hole is moved up to 0x1FD00000.
- R8: If a window begins below a hole and ends at or above that hole's exclusive top, its end is cut back to the hole's bottom. This rule is applied to the first hole and then to the second.
- R9: If trimming leaves an end at or below the base, the I/O window is disabled and no address hits it.
- R10: A changed mapping takes effect on the second rising edge after the write edge. `io_hit` and `io_offset` are registered: they reflect the address from the previous clock. The offset is the address minus the trimmed base, and it is zero on a miss.
- R11: The internal window is 4 KB long and starts at its register value << 21. `reg_hit` and `reg_offset` (address minus base, zero on a miss) are registered in the same way as the I/O outputs.
- R12: `rd_data` shows the register picked by `rd_sel` without waiting for a clock: 0 selects low, 1 selects high, 2 selects remap and 3 selects the internal window. The value is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 low, 1 high, 2 remap, 3 internal window |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read-back select, same encoding as `wr_sel` |
| rd_data | output | 32 | Selected register, zero-extended |
| cpu_addr | input | 32 | CPU physical address to decode |
| io_hit | output | 1 | Registered: the address fell inside the I/O window |
| io_offset | output | 32 | Registered: offset inside the I/O window |
| reg_hit | output | 1 | Registered: the address fell inside the internal window |
| reg_offset | output | 12 | Registered: offset inside the internal window |

## Verification
The assertions check on every cycle that an enabled I/O window never overlaps either reserved hole, and that a hit was reported only for an address inside the previous cycle's window. They also check that a disabled window never produces a hit, that an invalid decode leaves the mapping untouched, and that the write masks and the shadow remap load are applied. Only the bench scenarios can show the exact trimmed boundaries and offsets for each way a window can touch a hole. The same holds for the reset window and for the one-cycle delay before a new mapping is used, both of which the bench probes at chosen addresses.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

    localparam int ADDR_W       = 32;
    localparam int DATA_W       = 32;
    localparam int GRAN_SHIFT   = 21;
    localparam int LOW_W        = 15;
    localparam int HIGH_W       = 7;
    localparam int REMAP_W      = 11;
    localparam int REGWIN_W     = 15;
    localparam int REGWIN_OFF_W = 12;
    // one extra bit so base plus length never wraps
    localparam int MAP_W        = LOW_W + GRAN_SHIFT + 1;
    localparam int BLK_W        = HIGH_W + 1;

    localparam logic [MAP_W-1:0] HOLE_A_LO  = MAP_W'(32'h1E00_0000);
    localparam logic [MAP_W-1:0] HOLE_A_TOP = MAP_W'(32'h1F10_0000);
    localparam logic [MAP_W-1:0] HOLE_B_LO  = MAP_W'(32'h1FC0_0000);
    localparam logic [MAP_W-1:0] HOLE_B_TOP = MAP_W'(32'h1FD0_0000);
    localparam logic [MAP_W-1:0] REGWIN_LEN = MAP_W'(1) << REGWIN_OFF_W;

    typedef enum logic [1:0] {
        SEL_LOW    = 2'd0,
        SEL_HIGH   = 2'd1,
        SEL_REMAP  = 2'd2,
        SEL_REGWIN = 2'd3
    } win_sel_e;

    typedef struct packed {
        logic             en;
        logic [MAP_W-1:0] lo;   // first byte inside
        logic [MAP_W-1:0] hi;   // first byte past the end
    } span_t;

    function automatic logic decode_ok(input logic [LOW_W-1:0] low,
                                       input logic [HIGH_W-1:0] high);
        return low[HIGH_W-1:0] <= high;
    endfunction

    // base/length from the decode pair, then trim around the reserved holes
    function automatic span_t io_span_calc(input logic [LOW_W-1:0] low,
                                           input logic [HIGH_W-1:0] high);
        span_t            s;
        logic [BLK_W-1:0] blocks;
        logic [MAP_W-1:0] lo;
        logic [MAP_W-1:0] hi;
        blocks = ({1'b0, high} + BLK_W'(1)) - {1'b0, low[HIGH_W-1:0]};
        lo     = MAP_W'(low) << GRAN_SHIFT;
        hi     = lo + (MAP_W'(blocks) << GRAN_SHIFT);
        if (hi >= HOLE_A_LO && hi < HOLE_A_TOP) hi = HOLE_A_LO;
        if (lo >= HOLE_A_LO && lo < HOLE_A_TOP) lo = HOLE_A_TOP;
        if (hi >= HOLE_B_LO && hi < HOLE_B_TOP) hi = HOLE_B_LO;
        if (lo >= HOLE_B_LO && lo < HOLE_B_TOP) lo = HOLE_B_TOP;
        if (hi >= HOLE_A_TOP && lo < HOLE_A_LO) hi = HOLE_A_LO;
        if (hi >= HOLE_B_TOP && lo < HOLE_B_LO) hi = HOLE_B_LO;
        s.en = hi > lo;
        s.lo = lo;
        s.hi = hi;
        return s;
    endfunction

    function automatic span_t rw_span_calc(input logic [REGWIN_W-1:0] rw);
        span_t s;
        s.en = 1'b1;
        s.lo = MAP_W'(rw) << GRAN_SHIFT;
        s.hi = s.lo + REGWIN_LEN;
        return s;
    endfunction

endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
    import pciwin_pkg::*;
#(
    parameter logic [LOW_W-1:0]    LOW_RST    = 15'h080,
    parameter logic [HIGH_W-1:0]   HIGH_RST   = 7'h0F,
    parameter logic [REMAP_W-1:0]  REMAP_RST  = 11'h080,
    parameter logic [REGWIN_W-1:0] REGWIN_RST = 15'h0A0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  win_sel_e            wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [LOW_W-1:0]    low_o,
    output logic [HIGH_W-1:0]   high_o,
    output logic [REMAP_W-1:0]  remap_o,
    output logic [REGWIN_W-1:0] regwin_o,
    output logic                io_upd_o,
    output logic                rw_upd_o
);

    typedef struct packed {
        logic [LOW_W-1:0]    low;
        logic [HIGH_W-1:0]   high;
        logic [REMAP_W-1:0]  remap;
        logic [REGWIN_W-1:0] regwin;
        logic                io_upd;
        logic                rw_upd;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.io_upd = 1'b0;
        st_d.rw_upd = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                SEL_LOW: begin
                    st_d.low    = wr_data[LOW_W-1:0];
                    st_d.remap  = wr_data[REMAP_W-1:0];
                    st_d.io_upd = 1'b1;
                end
                SEL_HIGH: begin
                    st_d.high   = wr_data[HIGH_W-1:0];
                    st_d.io_upd = 1'b1;
                end
                SEL_REMAP: begin
                    st_d.remap  = wr_data[REMAP_W-1:0];
                end
                default: begin
                    st_d.regwin = wr_data[REGWIN_W-1:0];
                    st_d.rw_upd = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.low    <= LOW_RST;
            st_q.high   <= HIGH_RST;
            st_q.remap  <= REMAP_RST;
            st_q.regwin <= REGWIN_RST;
            st_q.io_upd <= 1'b0;
            st_q.rw_upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_o    = st_q.low;
    assign high_o   = st_q.high;
    assign remap_o  = st_q.remap;
    assign regwin_o = st_q.regwin;
    assign io_upd_o = st_q.io_upd;
    assign rw_upd_o = st_q.rw_upd;

endmodule

// File: rtl/pciwin_map.sv
module pciwin_map
    import pciwin_pkg::*;
#(
    parameter logic [LOW_W-1:0]    LOW_RST    = 15'h080,
    parameter logic [HIGH_W-1:0]   HIGH_RST   = 7'h0F,
    parameter logic [REGWIN_W-1:0] REGWIN_RST = 15'h0A0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LOW_W-1:0]    low_i,
    input  logic [HIGH_W-1:0]   high_i,
    input  logic [REGWIN_W-1:0] regwin_i,
    input  logic                io_upd_i,
    input  logic                rw_upd_i,
    output span_t               io_span_o,
    output span_t               rw_span_o
);

    typedef struct packed {
        span_t io;
        span_t rw;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        // an invalid decode pair leaves the last good mapping in place
        if (io_upd_i && decode_ok(low_i, high_i)) begin
            map_d.io = io_span_calc(low_i, high_i);
        end
        if (rw_upd_i) begin
            map_d.rw = rw_span_calc(regwin_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q.io <= io_span_calc(LOW_RST, HIGH_RST);
            map_q.rw <= rw_span_calc(REGWIN_RST);
        end else begin
            map_q <= map_d;
        end
    end

    assign io_span_o = map_q.io;
    assign rw_span_o = map_q.rw;

endmodule

// File: rtl/pciwin_match.sv
module pciwin_match
    import pciwin_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  span_t             span_i,
    output logic              hit_o,
    output logic [OFF_W-1:0]  off_o
);

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] off;
    } match_t;

    match_t           mt_d, mt_q;
    logic [MAP_W-1:0] addr_ext;
    logic [MAP_W-1:0] diff;
    logic             in_win;

    always_comb begin
        addr_ext = MAP_W'(addr_i);
        diff     = addr_ext - span_i.lo;
        in_win   = span_i.en && (addr_ext >= span_i.lo) && (addr_ext < span_i.hi);
        mt_d.hit = in_win;
        mt_d.off = in_win ? diff[OFF_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mt_q <= '0;
        end else begin
            mt_q <= mt_d;
        end
    end

    assign hit_o = mt_q.hit;
    assign off_o = mt_q.off;

endmodule

// File: rtl/pciwin_decoder.sv
module pciwin_decoder
    import pciwin_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [1:0]              rd_sel,
    output logic [DATA_W-1:0]       rd_data,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic                    io_hit,
    output logic [ADDR_W-1:0]       io_offset,
    output logic                    reg_hit,
    output logic [REGWIN_OFF_W-1:0] reg_offset
);

    localparam logic [LOW_W-1:0]    LOW_RST    = 15'h080;
    localparam logic [HIGH_W-1:0]   HIGH_RST   = 7'h0F;
    localparam logic [REMAP_W-1:0]  REMAP_RST  = 11'h080;
    localparam logic [REGWIN_W-1:0] REGWIN_RST = 15'h0A0;

    logic [LOW_W-1:0]    low_w;
    logic [HIGH_W-1:0]   high_w;
    logic [REMAP_W-1:0]  remap_w;
    logic [REGWIN_W-1:0] regwin_w;
    logic                io_upd_w;
    logic                rw_upd_w;
    span_t               io_span_w;
    span_t               rw_span_w;

    pciwin_regs #(
        .LOW_RST    (LOW_RST),
        .HIGH_RST   (HIGH_RST),
        .REMAP_RST  (REMAP_RST),
        .REGWIN_RST (REGWIN_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (win_sel_e'(wr_sel)),
        .wr_data  (wr_data),
        .low_o    (low_w),
        .high_o   (high_w),
        .remap_o  (remap_w),
        .regwin_o (regwin_w),
        .io_upd_o (io_upd_w),
        .rw_upd_o (rw_upd_w)
    );

    pciwin_map #(
        .LOW_RST    (LOW_RST),
        .HIGH_RST   (HIGH_RST),
        .REGWIN_RST (REGWIN_RST)
    ) u_map (
        .clk       (clk),
        .rst       (rst),
        .low_i     (low_w),
        .high_i    (high_w),
        .regwin_i  (regwin_w),
        .io_upd_i  (io_upd_w),
        .rw_upd_i  (rw_upd_w),
        .io_span_o (io_span_w),
        .rw_span_o (rw_span_w)
    );

    pciwin_match #(.OFF_W(ADDR_W)) u_io_match (
        .clk    (clk),
        .rst    (rst),
        .addr_i (cpu_addr),
        .span_i (io_span_w),
        .hit_o  (io_hit),
        .off_o  (io_offset)
    );

    pciwin_match #(.OFF_W(REGWIN_OFF_W)) u_rw_match (
        .clk    (clk),
        .rst    (rst),
        .addr_i (cpu_addr),
        .span_i (rw_span_w),
        .hit_o  (reg_hit),
        .off_o  (reg_offset)
    );

    always_comb begin
        case (win_sel_e'(rd_sel))
            SEL_LOW:   rd_data = DATA_W'(low_w);
            SEL_HIGH:  rd_data = DATA_W'(high_w);
            SEL_REMAP: rd_data = DATA_W'(remap_w);
            default:   rd_data = DATA_W'(regwin_w);
        endcase
    end

endmodule

// File: rtl/pciwin_decoder_chk.sv
module pciwin_decoder_chk
    import pciwin_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic [DATA_W-1:0]       wr_data,
    input logic [ADDR_W-1:0]       cpu_addr,
    input logic                    io_hit,
    input logic                    reg_hit,
    input logic [REGWIN_OFF_W-1:0] reg_offset,
    input logic [LOW_W-1:0]        low_q,
    input logic [HIGH_W-1:0]       high_q,
    input logic [REMAP_W-1:0]      remap_q,
    input logic                    io_upd,
    input span_t                   io_span
);

    logic [MAP_W-1:0] addr_ext;
    assign addr_ext = MAP_W'(cpu_addr);

    assert_low_loads_remap_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_LOW) |=> remap_q == $past(wr_data[REMAP_W-1:0]));

    assert_high_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_HIGH) |=> high_q == $past(wr_data[HIGH_W-1:0]));

    assert_invalid_keeps_map_R5: assert property (@(posedge clk) disable iff (rst)
        (io_upd && (low_q[HIGH_W-1:0] > high_q)) |=> $stable(io_span));

    assert_clear_of_hole_a_R6: assert property (@(posedge clk) disable iff (rst)
        io_span.en |-> !(io_span.lo < HOLE_A_TOP && io_span.hi > HOLE_A_LO));

    assert_clear_of_hole_b_R7: assert property (@(posedge clk) disable iff (rst)
        io_span.en |-> !(io_span.lo < HOLE_B_TOP && io_span.hi > HOLE_B_LO));

    assert_disabled_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
        !io_span.en |=> !io_hit);

    assert_hit_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> ($past(io_span.en) && $past(addr_ext) >= $past(io_span.lo)
                    && $past(addr_ext) < $past(io_span.hi)));

    assert_reg_offset_R11: assert property (@(posedge clk) disable iff (rst)
        reg_hit |-> reg_offset == $past(cpu_addr[REGWIN_OFF_W-1:0]));

endmodule

bind pciwin_decoder pciwin_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .cpu_addr   (cpu_addr),
    .io_hit     (io_hit),
    .reg_hit    (reg_hit),
    .reg_offset (reg_offset),
    .low_q      (low_w),
    .high_q     (high_w),
    .remap_q    (remap_w),
    .io_upd     (io_upd_w),
    .io_span    (io_span_w)
);

// File: tb/pciwin_decoder_test.sv
module pciwin_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [31:0] cpu_addr = '0;
    logic        io_hit;
    logic [31:0] io_offset;
    logic        reg_hit;
    logic [11:0] reg_offset;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pciwin_decoder uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .cpu_addr   (cpu_addr),
        .io_hit     (io_hit),
        .io_offset  (io_offset),
        .reg_hit    (reg_hit),
        .reg_offset (reg_offset)
    );

    typedef struct packed {
        logic [14:0] low;
        logic [6:0]  high;
        logic [31:0] addr;
        logic        hit;
        logic [31:0] off;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{15'h080, 7'h0F, 32'h1000_0000, 1'b1, 32'h0000_0000}, // R5 base
        '{15'h080, 7'h0F, 32'h11FF_FFFC, 1'b1, 32'h01FF_FFFC}, // R5 last word
        '{15'h080, 7'h0F, 32'h1200_0000, 1'b0, 32'h0},         // R5 past end
        '{15'h080, 7'h0F, 32'h0FFF_FFFF, 1'b0, 32'h0},         // R5 below base
        '{15'h005, 7'h06, 32'h00C0_0010, 1'b1, 32'h0020_0010}, // R5 small window
        '{15'h005, 7'h06, 32'h00E0_0000, 1'b0, 32'h0},         // R5
        '{15'h0E8, 7'h70, 32'h1DFF_FFF0, 1'b1, 32'h00FF_FFF0}, // R6 end pulled down
        '{15'h0E8, 7'h70, 32'h1E00_0000, 1'b0, 32'h0},         // R6
        '{15'h0F4, 7'h7B, 32'h1F10_0000, 1'b1, 32'h0},         // R6 base pushed up
        '{15'h0F4, 7'h7B, 32'h1F0F_FFFC, 1'b0, 32'h0},         // R6
        '{15'h0F4, 7'h7B, 32'h1F7F_FFFC, 1'b1, 32'h006F_FFFC}, // R6
        '{15'h0E0, 7'h7F, 32'h1DFF_FFFC, 1'b1, 32'h01FF_FFFC}, // R8 straddle first hole
        '{15'h0E0, 7'h7F, 32'h1F20_0000, 1'b0, 32'h0},         // R8
        '{15'h0FE, 7'h7E, 32'h1FC8_0000, 1'b0, 32'h0},         // R7 base in second hole
        '{15'h0FE, 7'h7E, 32'h1FD0_0004, 1'b1, 32'h0000_0004}, // R7
        '{15'h0FC, 7'h7F, 32'h1FBF_FFFC, 1'b1, 32'h003F_FFFC}, // R8 straddle second hole
        '{15'h0FC, 7'h7F, 32'h1FE0_0000, 1'b0, 32'h0},         // R8
        '{15'h0F0, 7'h70, 32'h1E00_0000, 1'b0, 32'h0},         // R9 trimmed to nothing
        '{15'h0F0, 7'h70, 32'h1F10_0000, 1'b0, 32'h0}          // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns after the write edge
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [31:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic probe_io(input string tag, input logic [31:0] a,
                            input logic hit, input logic [31:0] off);
        cpu_addr = a;
        @(negedge clk);
        chk({tag, " io_hit"}, {31'b0, io_hit}, {31'b0, hit});
        chk({tag, " io_offset"}, io_offset, off);
    endtask

    task automatic probe_rw(input string tag, input logic [31:0] a,
                            input logic hit, input logic [11:0] off);
        cpu_addr = a;
        @(negedge clk);
        chk({tag, " reg_hit"}, {31'b0, reg_hit}, {31'b0, hit});
        chk({tag, " reg_offset"}, {20'b0, reg_offset}, {20'b0, off});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4 / R12: reset contents and read-back encoding
        chk("R4 io_hit after reset", {31'b0, io_hit}, 32'h0);
        rd_chk("R4 R12 low", 2'd0, 32'h080);
        rd_chk("R4 R12 high", 2'd1, 32'h00F);
        rd_chk("R4 R12 remap", 2'd2, 32'h080);
        rd_chk("R4 R12 regwin", 2'd3, 32'h0A0);
        probe_io("R4 reset window", 32'h1000_0004, 1'b1, 32'h4);
        probe_io("R4 reset window end", 32'h1200_0000, 1'b0, 32'h0);
        probe_rw("R4 R11 reset internal", 32'h1400_0FFC, 1'b1, 12'hFFC);
        probe_rw("R11 internal past 4KB", 32'h1400_1000, 1'b0, 12'h0);

        // R1 R2 R3: write masks
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk("R1 low mask", 2'd0, 32'h7FFF);
        rd_chk("R2 remap shadow", 2'd2, 32'h07FF);
        wr(2'd1, 32'hFFFF_FFFF);
        rd_chk("R3 high mask", 2'd1, 32'h7F);
        wr(2'd2, 32'hFFFF_1234);
        rd_chk("R3 remap mask", 2'd2, 32'h234);
        rd_chk("R3 remap write leaves low", 2'd0, 32'h7FFF);
        wr(2'd3, 32'hFFFF_80A8);
        rd_chk("R3 regwin mask", 2'd3, 32'h0A8);
        @(negedge clk);

        // R11: moved internal window
        probe_rw("R11 new internal", 32'h1500_0010, 1'b1, 12'h010);
        probe_rw("R11 old internal gone", 32'h1400_0000, 1'b0, 12'h0);
        probe_rw("R11 end", 32'h1500_1000, 1'b0, 12'h0);

        // table walk: R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {17'b0, VECS[i].low});
            wr(2'd1, {25'b0, VECS[i].high});
            @(negedge clk);
            probe_io($sformatf("R5-table vec%0d", i), VECS[i].addr, VECS[i].hit, VECS[i].off);
        end

        // R10: new mapping not used at the first edge after the write
        wr(2'd0, 32'h080);
        wr(2'd1, 32'h00F);
        @(negedge clk);
        wr(2'd0, 32'h100);
        probe_io("R10 old map still live", 32'h2000_0000, 1'b0, 32'h0);
        probe_io("R10 new map live", 32'h2000_0000, 1'b1, 32'h0);
        probe_io("R10 offset", 32'h2123_4568, 1'b1, 32'h0123_4568);

        // R5: invalid pair keeps previous mapping
        wr(2'd0, 32'h190);
        rd_chk("R5 invalid low stored", 2'd0, 32'h190);
        @(negedge clk);
        probe_io("R5 invalid keeps map", 32'h2000_0000, 1'b1, 32'h0);
        probe_io("R5 invalid no new map", 32'h3200_0000, 1'b0, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule